// File: doc/BRIEF.md
# Word Shift and Rotate Unit

This block moves the bits of a 36-bit accumulator word in one of three ways. It can do an arithmetic shift, which keeps the sign. It can do a logical shift, which fills with zeros. It can do a circular rotate. A single 18-bit effective-address value carries both the direction and the distance. The direction bit sits at the top of that value. The distance is read from its low byte as a signed count.

An operation is offered with a valid/ready pair. It is taken on any clock edge where both are high. The registered result appears on the next cycle, together with a one-cycle result strobe. For an arithmetic left shift, an overflow flag reports whether any bit pushed out of the magnitude field differed from the sign. The result and flag hold their values until the next accepted operation.

Top module: `word_shift_unit`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 from the first edge after reset is released. `res_valid` is 1 in exactly the cycle after each acceptance and 0 otherwise. `res_word` and `res_ovf` hold their values while no operation is accepted.
- R2: Direction is bit 17 of `in_ea` (0 = left, 1 = right). For a left move the distance is `in_ea[7:0]` read unsigned. For a right move the distance is `(256 - in_ea[7:0]) mod 256`. Bits 16 to 8 of `in_ea` have no effect on the result.
- R3: An arithmetic right shift (mode 0) copies bit 35 into every vacated high position. A distance of 36 or more gives a word made entirely of the sign bit.
- R4: An arithmetic left shift (mode 0) keeps bit 35 unchanged and fills bits 34..0 from below with zeros. A distance of 35 or more leaves bits 34..0 all zero.
- R5: A logical shift (mode 1) fills vacated positions with zeros in both directions. A distance of 36 or more gives an all-zero word.
- R6: A rotate (mode 2) moves bits circularly in the chosen direction by the distance modulo 36, so the number of one bits is unchanged.
- R7: `res_ovf` is 1 only for an arithmetic left shift in which some bit leaving position 34 differs from the original bit 35. It is 0 for every other mode and direction.
- R8: Mode code 3 behaves exactly like the logical shift.
- R9: While `rst_n` is low at a clock edge, `res_valid`, `res_ovf` and `in_ready` become 0 and `res_word` becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_word | input | 36 | Accumulator word to move |
| in_ea | input | 18 | Effective address carrying direction and distance |
| in_mode | input | 2 | 0 arithmetic, 1 logical, 2 rotate, 3 logical |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_word | output | 36 | Registered result word |
| res_ovf | output | 1 | Sign lost in an arithmetic left shift |

## Verification
A mistake in the stage-select or saturation logic shows as a wrong word on the first result that uses the affected distance bit. It appears on the cycle right after acceptance, so each check compares within one clock of the stimulus. A broken direction or reversal path damages every right-going result. An overflow mask error shows only for arithmetic left shifts near the sign boundary. For that reason, the directed cases place a differing bit just inside and just outside the shifted-out window. The strobe and hold behaviour are checked on back-to-back and idle cycles, so a strobe that sticks or a result register that updates without acceptance is caught on the next sample.

// File: rtl/wsr_pkg.sv
// Shared types for the word shift and rotate unit.
// Assumes a two-bit mode code; code 3 is handled as a logical shift.
package wsr_pkg;
    typedef enum logic [1:0] {
        MODE_ARITH = 2'd0,
        MODE_LOGIC = 2'd1,
        MODE_ROT   = 2'd2,
        MODE_ALT   = 2'd3
    } wsr_mode_e;
endpackage

// File: rtl/wsr_count_decode.sv
// Turns the effective address into a direction and a stage-select amount.
// Assumes the direction flag is the top bit of the address and W < 2**MAG_W.
// Shift amounts saturate at W; rotate amounts are reduced modulo W.
module wsr_count_decode #(
    parameter int W     = 36,
    parameter int EA_W  = 18,
    parameter int MAG_W = 8,
    localparam int AW   = $clog2(W + 1)
) (
    input  logic [EA_W-1:0] ea_i,
    input  logic            rot_i,
    output logic            right_o,
    output logic [AW-1:0]   amt_o
);
    localparam int DIR_BIT = EA_W - 1;

    logic [MAG_W-1:0] mag;
    logic             unused_mid;

    assign unused_mid = ^ea_i[DIR_BIT-1:MAG_W];
    assign right_o    = ea_i[DIR_BIT];

    // Magnitude: negate the low byte when the count is negative.
    always_comb begin
        if (right_o) mag = MAG_W'(0) - ea_i[MAG_W-1:0];
        else         mag = ea_i[MAG_W-1:0];
    end

    // Amount: modulo for rotate, saturated for shifts.
    always_comb begin
        if (rot_i)                 amt_o = AW'(mag % MAG_W'(W));
        else if (mag >= MAG_W'(W)) amt_o = AW'(W);
        else                       amt_o = AW'(mag);
    end
endmodule

// File: rtl/wsr_barrel.sv
// Log-stage left barrel: shift-with-fill or rotate, one stage per amount bit.
// Assumes amt_i < W when rot_i is set; larger stages then only fill.
module wsr_barrel #(
    parameter int W  = 36,
    parameter int AW = 6
) (
    input  logic [W-1:0]  d_i,
    input  logic [AW-1:0] amt_i,
    input  logic          rot_i,
    input  logic          fill_i,
    output logic [W-1:0]  d_o
);
    logic [W-1:0] stg [AW+1];

    assign stg[0] = d_i;

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int SH = 1 << i;
        if (SH < W) begin : g_part
            // Stage i moves by 2**i when its amount bit is set.
            assign stg[i+1] = !amt_i[i] ? stg[i] :
                              rot_i ? {stg[i][W-1-SH:0], stg[i][W-1:W-SH]} :
                                      {stg[i][W-1-SH:0], {SH{fill_i}}};
        end else begin : g_full
            // Stage moves by W or more: everything is fill.
            assign stg[i+1] = amt_i[i] ? {W{fill_i}} : stg[i];
        end
    end

    assign d_o = stg[AW];
endmodule

// File: rtl/wsr_core.sv
// Combinational shift core: right moves use bit reversal around the left barrel.
// Assumes amt_i is already saturated or reduced by the decoder.
module wsr_core
    import wsr_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 6
) (
    input  logic [W-1:0]  word_i,
    input  wsr_mode_e     mode_i,
    input  logic          right_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  word_o,
    output logic          ovf_o
);
    function automatic logic [W-1:0] rev(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int k = 0; k < W; k++) y[k] = x[W-1-k];
        return y;
    endfunction

    logic         sign, is_arith, is_rot, fill;
    logic [W-1:0] pre, moved, post;
    logic [W-2:0] out_mask;

    assign sign     = word_i[W-1];
    assign is_arith = (mode_i == MODE_ARITH);
    assign is_rot   = (mode_i == MODE_ROT);
    assign fill     = is_arith && right_i && sign;
    assign pre      = right_i ? rev(word_i) : word_i;

    wsr_barrel #(.W(W), .AW(AW)) barrel_i (
        .d_i    (pre),
        .amt_i  (amt_i),
        .rot_i  (is_rot),
        .fill_i (fill),
        .d_o    (moved)
    );

    // Undo reversal; an arithmetic left shift restores the sign bit.
    always_comb begin
        post = right_i ? rev(moved) : moved;
        if (is_arith && !right_i) post[W-1] = sign;
    end

    // Top amt_i positions of the magnitude field leave the word.
    assign out_mask = ~({(W-1){1'b1}} >> amt_i);
    assign ovf_o    = is_arith && !right_i &&
                      (|((word_i[W-2:0] ^ {(W-1){sign}}) & out_mask));
    assign word_o   = post;
endmodule

// File: rtl/word_shift_unit.sv
// Top: accepts one operation per cycle and registers the result with a strobe.
// Assumes the consumer takes res_word when res_valid is high; no output stall.
module word_shift_unit
    import wsr_pkg::*;
#(
    parameter int W     = 36,
    parameter int EA_W  = 18,
    parameter int MAG_W = 8,
    localparam int AW   = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [W-1:0]    in_word,
    input  logic [EA_W-1:0] in_ea,
    input  logic [1:0]      in_mode,
    output logic            res_valid,
    output logic [W-1:0]    res_word,
    output logic            res_ovf
);
    wsr_mode_e     mode;
    logic          right, accept, ovf_c;
    logic [AW-1:0] amt;
    logic [W-1:0]  word_c;

    assign mode   = wsr_mode_e'(in_mode);
    assign accept = in_valid && in_ready;

    wsr_count_decode #(.W(W), .EA_W(EA_W), .MAG_W(MAG_W)) dec_i (
        .ea_i    (in_ea),
        .rot_i   (mode == MODE_ROT),
        .right_o (right),
        .amt_o   (amt)
    );

    wsr_core #(.W(W), .AW(AW)) core_i (
        .word_i  (in_word),
        .mode_i  (mode),
        .right_i (right),
        .amt_i   (amt),
        .word_o  (word_c),
        .ovf_o   (ovf_c)
    );

    // Ready rises once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Strobe for one cycle after each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= accept;
    end

    // Capture result and flag only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_word <= '0;
            res_ovf  <= 1'b0;
        end else if (accept) begin
            res_word <= word_c;
            res_ovf  <= ovf_c;
        end
    end

    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_ready));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(res_word));

    p_sign_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == MODE_ARITH) |=> res_word[W-1] == $past(in_word[W-1]));

    p_rot_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == MODE_ROT) |=> $countones(res_word) == $countones($past(in_word)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(mode == MODE_ARITH && !in_ea[EA_W-1])) |=> !res_ovf);
endmodule

// File: tb/word_shift_unit_tb_top.sv
module word_shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [35:0] in_word = '0;
    logic [17:0] in_ea = '0;
    logic [1:0]  in_mode = '0;
    logic        res_valid;
    logic [35:0] res_word;
    logic        res_ovf;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    word_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_ea(in_ea), .in_mode(in_mode),
        .res_valid(res_valid), .res_word(res_word), .res_ovf(res_ovf)
    );

    // Reference from the requirements: returns {ovf, word}.
    function automatic logic [36:0] model(input logic [35:0] w, input logic [17:0] ea,
                                          input logic [1:0] m);
        logic [35:0] r;
        logic        ov, rt, s;
        int          mag, k, src;
        rt  = ea[17];
        mag = rt ? ((256 - int'(ea[7:0])) % 256) : int'(ea[7:0]);
        s   = w[35];
        ov  = 1'b0;
        r   = '0;
        if (m == 2'd2) begin
            k = mag % 36;
            for (int i = 0; i < 36; i++)
                r[i] = rt ? w[(i + k) % 36] : w[(i - k + 36) % 36];
        end else if (m == 2'd0 && rt) begin
            for (int i = 0; i < 36; i++) begin
                src  = i + mag;
                r[i] = (src < 36) ? w[src] : s;
            end
        end else if (m == 2'd0) begin
            r[35] = s;
            for (int i = 0; i < 35; i++) begin
                src  = i - mag;
                r[i] = (src >= 0) ? w[src] : 1'b0;
                if (i + mag > 34 && w[i] != s) ov = 1'b1;
            end
        end else begin
            for (int i = 0; i < 36; i++) begin
                src  = rt ? i + mag : i - mag;
                r[i] = (src >= 0 && src < 36) ? w[src] : 1'b0;
            end
        end
        return {ov, r};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [36:0] act,
                       input logic [36:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; the result is sampled at the next falling edge.
    task automatic op(input logic [35:0] w, input logic [17:0] ea, input logic [1:0] m,
                      input string tag);
        logic [36:0] e;
        in_valid = 1'b1; in_word = w; in_ea = ea; in_mode = m;
        e = model(w, ea, m);
        @(negedge clk);
        chk(res_valid == 1'b1, "R1 strobe", {36'd0, res_valid}, 37'd1);
        chk({res_ovf, res_word} == e, tag, {res_ovf, res_word}, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] held;
        logic [17:0] ea_r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({in_ready, res_valid, res_ovf, res_word} == 39'd0, "R9 reset",
            {res_ovf, res_word}, 37'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready", {36'd0, in_ready}, 37'd1);
        chk(res_valid == 1'b0, "R1 idle strobe", {36'd0, res_valid}, 37'd0);

        // Directed corners.
        op(36'h8_0000_0010, 18'h3FFFD, 2'd0, "R3 arith right 3");
        op(36'h8_0000_0010, 18'h3FFD8, 2'd0, "R3 arith right 40");
        op(36'h0_0000_0001, 18'h00002, 2'd0, "R4 arith left 2");
        op(36'h2_0000_0000, 18'h00001, 2'd0, "R4 R7 no ovf edge");
        op(36'h2_0000_0000, 18'h00002, 2'd0, "R4 R7 ovf set");
        op(36'hF_FFFF_FFFF, 18'h00023, 2'd0, "R4 R7 left 35 neg");
        op(36'h0_0000_0001, 18'h00023, 2'd0, "R4 R7 left 35 ovf");
        op(36'hF_0000_000F, 18'h00024, 2'd1, "R5 logical left 36");
        op(36'hF_0000_000F, 18'h3FFFC, 2'd1, "R5 logical right 4");
        op(36'hF_0000_000F, 18'h3FFF0, 2'd1, "R5 R7 logical right 16");
        op(36'h8_0000_0001, 18'h00025, 2'd2, "R6 rotate left 37");
        op(36'h8_0000_0001, 18'h3FFFF, 2'd2, "R6 rotate right 1");
        op(36'h8_0000_0001, 18'h3FFB8, 2'd2, "R6 rotate right 72");
        op(36'hC_1234_5678, 18'h3FF00, 2'd0, "R2 right zero distance");
        op(36'hC_1234_5678, 18'h3FFF9, 2'd3, "R8 mode 3 right 7");
        op(36'hC_1234_5678, 18'h00005, 2'd3, "R8 mode 3 left 5");
        op(36'h8_1234_5678, 18'h1AB04, 2'd0, "R2 middle bits ignored");

        // R1 idle: strobe drops and result holds.
        held = res_word;
        in_valid = 1'b0;
        in_word = 36'h5_5555_5555;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 strobe low", {36'd0, res_valid}, 37'd0);
        chk(res_word == held, "R1 hold", {1'b0, res_word}, {1'b0, held});

        // Random mix, back to back.
        for (int n = 0; n < 400; n++) begin
            ea_r = 18'($urandom);
            if ($urandom % 4 != 0) ea_r[7:0] = 8'($urandom % 48);
            if (ea_r[17] && ea_r[7:0] != 8'd0 && ($urandom % 2 == 0))
                ea_r[7:0] = 8'd0 - ea_r[7:0];
            op({$urandom, 4'($urandom)}, ea_r, 2'($urandom), "R2 R3 R4 R5 R6 R7 random");
        end
        in_valid = 1'b0;
        @(negedge clk);

        // R9 reset in mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        chk({in_ready, res_valid, res_ovf, res_word} == 39'd0, "R9 reset again",
            {res_ovf, res_word}, 37'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule